// File: doc/BRIEF.md
# Passive FPGA Configuration Loader

This block is the master side of a passive configuration link to a target FPGA. A start pulse together with a byte total begins a load. The block first holds the target's active-low configuration reset low for a fixed time, then releases it and waits for the target to wake up. After that it pulls bitstream bytes from a ready/valid byte stream and clocks them into the target. Each byte goes out either as eight serial bits on one line, least significant bit first, or as one 8-bit word on a parallel bus. A secure variant of the parallel mode adds three more clock pulses after each byte's first pulse.

The target's status line is sampled before every byte. If it has dropped, the load stops and the block reports how many bytes were fully sent. After the last byte the block gives one final rising edge and keeps the clock high for a settling time. It then samples the target's done line and reports success or failure. Every delay and both clock phases are counted in system clock cycles and set by parameters.

Top module: `cfg_loader`

## Requirements
- R1: After reset the block is idle: busy_o, ok_o, err_o, s_ready_o and cfg_clk_o are 0, cfg_rst_n_o is 1, and fail_count_o is 0.
- R2: An accepted start (start_i high while idle with a non-zero total) drives cfg_rst_n_o low for exactly RST_LOW_CYC cycles, then releases it high.
- R3: cfg_clk_o is low when cfg_rst_n_o is released, and at least WAKE_CYC cycles pass between that release and the first rising edge of cfg_clk_o.
- R4: The data outputs do not change while cfg_clk_o stays high. Each data clock pulse is high for CLK_HI_CYC cycles, and the clock is low for at least CLK_LO_CYC cycles before every rising edge. No rising edge occurs beyond those the mode calls for.
- R5: s_ready_o is high only while the block is waiting for the next byte with the clock low. A byte is taken when s_valid_i and s_ready_o are both high at a clock edge.
- R6: Before each byte, tgt_status_i must be high. s_ready_o is never high while it is low. If it is low while a byte is awaited, the load aborts with err_o set and fail_count_o equal to the number of bytes whose clock pulses were all issued.
- R7: With mode code 0 (serial), each byte is shifted out on cfg_ser_o least significant bit first, with one clock pulse per bit. cfg_par_o stays 0.
- R8: With mode code 1 or 3 (parallel), the whole byte is presented on cfg_par_o with one clock pulse. cfg_ser_o stays 0.
- R9: With mode code 2 (secure parallel), each byte is presented on cfg_par_o and given four clock pulses.
- R10: After the last byte the clock gets one more rising edge and stays high for DONE_WAIT_CYC cycles, then tgt_done_i is sampled. If it is high, ok_o is set. If it is low, the load aborts with fail_count_o equal to the byte total. ok_o and err_o are never high together.
- R11: A start with a total of 0 sets err_o on the next cycle, with fail_count_o 0. busy_o stays low and cfg_rst_n_o and cfg_clk_o are not touched.
- R12: An abort leaves cfg_rst_n_o low, cfg_clk_o low and both data outputs 0. err_o stays set until the next accepted start, which clears ok_o, err_o and fail_count_o.
- R13: start_i is ignored while busy_o is high. The mode and the byte total are captured when start is accepted, so later changes on mode_i and total_bytes_i have no effect on a load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| total_bytes_i | input | CNT_W | Number of bitstream bytes to load |
| mode_i | input | 2 | 0 serial, 1 or 3 parallel, 2 secure parallel |
| s_data_i | input | 8 | Bitstream byte from the stream |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Block can take a byte |
| cfg_rst_n_o | output | 1 | Active-low configuration reset to the target |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_ser_o | output | 1 | Serial data line |
| cfg_par_o | output | 8 | Parallel data bus |
| tgt_status_i | input | 1 | Target status, high when healthy |
| tgt_done_i | input | 1 | Target configuration-done |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded (sticky) |
| err_o | output | 1 | Last load failed (sticky) |
| fail_count_o | output | CNT_W | Bytes fully sent when the last load failed |

## Verification
The bench goes after bit order and pulse count. A serial shifter that starts from the most significant bit, or a secure mode that issues three or five pulses, leaves the monitor popping the wrong expected value or finding an unexpected rising edge. The status line is dropped in the middle of a load, right after a byte's last pulse. A design that checks status only once, or counts the pending byte as sent, would go on clocking or report a count of three instead of two. Other cases are a low done line at the end, a zero byte total, and a second start with a different mode and total while busy. A design that re-latches its inputs would change bit order or length. A design that treats zero as a normal load would pulse the configuration reset.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration loader: mode codes and controller states.
// Assumes a two-bit mode input; code 3 is decoded the same as plain parallel.
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        MODE_SERIAL   = 2'd0,
        MODE_PARALLEL = 2'd1,
        MODE_SECURE   = 2'd2,
        MODE_PAR_ALT  = 2'd3
    } cfg_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_WAKE,
        ST_FETCH,
        ST_SETUP,
        ST_HIGH,
        ST_TAIL_LOW,
        ST_FINAL_HIGH,
        ST_ABORT
    } ld_state_e;

    localparam int BYTE_BITS     = 8;
    localparam int SECURE_PULSES = 4;

endpackage

// File: rtl/cfg_delay_timer.sv
// Down counter for phase and delay timing. Loading value N-1 makes the
// owning state last N cycles. zero_o is high while the count is 0.
// Assumes load_i and a non-zero count never need to coexist with reset.
module cfg_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load a new count, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfg_byte_shifter.sv
// Holds the byte under transfer. A shift moves the next serial bit into
// position 0. Clear has priority over load, and load over shift.
module cfg_byte_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [BITS-1:0] data_i,
    output logic [BITS-1:0] byte_o
);

    logic [BITS-1:0] byte_q;

    // Keep the byte, clear it on abort and shift it right for serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (clear_i) begin
            byte_q <= '0;
        end else if (load_i) begin
            byte_q <= data_i;
        end else if (shift_i) begin
            byte_q <= {1'b0, byte_q[BITS-1:1]};
        end
    end

    assign byte_o = byte_q;

endmodule

// File: rtl/cfg_loader.sv
// Passive-mode configuration master. It pulses the target's configuration
// reset, waits for wake-up, then streams bytes serially (LSB first) or in
// parallel, with optional extra clocks per byte. It checks target status
// before each byte and done at the end.
// Assumes the delay parameters are all at least 1 and counted in clk cycles.
module cfg_loader #(
    parameter int CNT_W         = 16,
    parameter int RST_LOW_CYC   = 500,
    parameter int WAKE_CYC      = 10000,
    parameter int DONE_WAIT_CYC = 10000,
    parameter int CLK_HI_CYC    = 2,
    parameter int CLK_LO_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_bytes_i,
    input  logic [1:0]       mode_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             cfg_rst_n_o,
    output logic             cfg_clk_o,
    output logic             cfg_ser_o,
    output logic [7:0]       cfg_par_o,
    input  logic             tgt_status_i,
    input  logic             tgt_done_i,
    output logic             busy_o,
    output logic             ok_o,
    output logic             err_o,
    output logic [CNT_W-1:0] fail_count_o
);
    import cfg_loader_pkg::*;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_DLY = imax(imax(imax(RST_LOW_CYC, WAKE_CYC), DONE_WAIT_CYC),
                                  imax(CLK_HI_CYC, CLK_LO_CYC));
    localparam int TMR_W   = $clog2(MAX_DLY + 1);
    localparam int PULSE_W = $clog2(BYTE_BITS + 1);
    localparam logic [TMR_W-1:0] RST_V  = TMR_W'(RST_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] WAKE_V = TMR_W'(WAKE_CYC - 1);
    localparam logic [TMR_W-1:0] DONE_V = TMR_W'(DONE_WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] HI_V   = TMR_W'(CLK_HI_CYC - 1);
    localparam logic [TMR_W-1:0] LO_V   = TMR_W'(CLK_LO_CYC - 1);

    ld_state_e          state_q, state_nxt;
    cfg_mode_e          mode_q;
    logic [CNT_W-1:0]   total_q, bytes_done_q, fail_cnt_q;
    logic [PULSE_W-1:0] pulses_left_q;
    logic               cfg_rst_n_q, ok_q, err_q;

    logic               tmr_load, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic               sh_load, sh_shift, sh_clear;
    logic [7:0]         sh_byte;
    logic               accept_start, zero_reject;
    logic               last_pulse, last_byte;

    cfg_delay_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    cfg_byte_shifter #(.BITS(BYTE_BITS)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sh_clear),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .data_i  (s_data_i),
        .byte_o  (sh_byte)
    );

    assign last_pulse = (pulses_left_q == PULSE_W'(1));
    assign last_byte  = ((bytes_done_q + CNT_W'(1)) == total_q);

    // Next-state decode, timer reloads and shifter control for the sequence.
    always_comb begin
        state_nxt    = state_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        sh_load      = 1'b0;
        sh_shift     = 1'b0;
        sh_clear     = 1'b0;
        accept_start = 1'b0;
        zero_reject  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (total_bytes_i == '0) begin
                        zero_reject = 1'b1;
                    end else begin
                        accept_start = 1'b1;
                        sh_clear     = 1'b1;
                        tmr_load     = 1'b1;
                        tmr_val      = RST_V;
                        state_nxt    = ST_RST_LOW;
                    end
                end
            end
            ST_RST_LOW: begin
                if (tmr_zero) begin
                    tmr_load  = 1'b1;
                    tmr_val   = WAKE_V;
                    state_nxt = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (tmr_zero) state_nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (!tgt_status_i) begin
                    state_nxt = ST_ABORT;
                end else if (s_valid_i) begin
                    sh_load   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LO_V;
                    state_nxt = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    tmr_load  = 1'b1;
                    tmr_val   = HI_V;
                    state_nxt = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    if (last_pulse) begin
                        if (last_byte) begin
                            tmr_load  = 1'b1;
                            tmr_val   = LO_V;
                            state_nxt = ST_TAIL_LOW;
                        end else begin
                            state_nxt = ST_FETCH;
                        end
                    end else begin
                        sh_shift  = (mode_q == MODE_SERIAL);
                        tmr_load  = 1'b1;
                        tmr_val   = LO_V;
                        state_nxt = ST_SETUP;
                    end
                end
            end
            ST_TAIL_LOW: begin
                if (tmr_zero) begin
                    tmr_load  = 1'b1;
                    tmr_val   = DONE_V;
                    state_nxt = ST_FINAL_HIGH;
                end
            end
            ST_FINAL_HIGH: begin
                if (tmr_zero) state_nxt = tgt_done_i ? ST_IDLE : ST_ABORT;
            end
            ST_ABORT: begin
                sh_clear  = 1'b1;
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State, captured request, byte and pulse counters, and sticky result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            mode_q        <= MODE_SERIAL;
            total_q       <= '0;
            bytes_done_q  <= '0;
            fail_cnt_q    <= '0;
            pulses_left_q <= '0;
            cfg_rst_n_q   <= 1'b1;
            ok_q          <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (zero_reject) begin
                ok_q       <= 1'b0;
                err_q      <= 1'b1;
                fail_cnt_q <= '0;
            end
            if (accept_start) begin
                mode_q       <= cfg_mode_e'(mode_i);
                total_q      <= total_bytes_i;
                bytes_done_q <= '0;
                fail_cnt_q   <= '0;
                ok_q         <= 1'b0;
                err_q        <= 1'b0;
                cfg_rst_n_q  <= 1'b0;
            end
            if (state_q == ST_RST_LOW && tmr_zero) begin
                cfg_rst_n_q <= 1'b1;
            end
            if (sh_load) begin
                if (mode_q == MODE_SERIAL)      pulses_left_q <= PULSE_W'(BYTE_BITS);
                else if (mode_q == MODE_SECURE) pulses_left_q <= PULSE_W'(SECURE_PULSES);
                else                            pulses_left_q <= PULSE_W'(1);
            end
            if (state_q == ST_HIGH && tmr_zero) begin
                pulses_left_q <= pulses_left_q - PULSE_W'(1);
                if (last_pulse) bytes_done_q <= bytes_done_q + CNT_W'(1);
            end
            if (state_q == ST_FINAL_HIGH && tmr_zero && tgt_done_i) begin
                ok_q <= 1'b1;
            end
            if (state_q == ST_ABORT) begin
                err_q       <= 1'b1;
                fail_cnt_q  <= bytes_done_q;
                cfg_rst_n_q <= 1'b0;
            end
        end
    end

    assign s_ready_o    = (state_q == ST_FETCH) && tgt_status_i;
    assign cfg_clk_o    = (state_q == ST_HIGH) || (state_q == ST_FINAL_HIGH);
    assign cfg_rst_n_o  = cfg_rst_n_q;
    assign cfg_ser_o    = (mode_q == MODE_SERIAL) ? sh_byte[0] : 1'b0;
    assign cfg_par_o    = (mode_q == MODE_SERIAL) ? 8'h00 : sh_byte;
    assign busy_o       = (state_q != ST_IDLE);
    assign ok_o         = ok_q;
    assign err_o        = err_q;
    assign fail_count_o = fail_cnt_q;

endmodule

// File: rtl/cfg_loader_checker.sv
// Protocol checker for cfg_loader, attached with bind. It only observes ports.
module cfg_loader_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] total_bytes_i,
    input logic             s_ready_o,
    input logic             cfg_rst_n_o,
    input logic             cfg_clk_o,
    input logic             cfg_ser_o,
    input logic [7:0]       cfg_par_o,
    input logic             tgt_status_i,
    input logic             busy_o,
    input logic             ok_o,
    input logic             err_o
);

    a_r5_ready_only_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !cfg_clk_o && busy_o);

    a_r6_ready_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> tgt_status_i);

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_o && $past(cfg_clk_o)) |-> ($stable(cfg_par_o) && $stable(cfg_ser_o)));

    a_r3_release_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rst_n_o) |-> !cfg_clk_o);

    a_r12_reset_low_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n_o |-> !cfg_clk_o);

    a_r11_zero_total_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && total_bytes_i == '0) |=> (err_o && !busy_o && cfg_rst_n_o == $past(cfg_rst_n_o)));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));

    a_r13_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cfg_clk_o);

endmodule

bind cfg_loader cfg_loader_checker #(.CNT_W(CNT_W)) u_checker (.*);

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;

    localparam int CLK_PERIOD    = 10;
    localparam int CNT_W         = 16;
    localparam int RST_LOW_CYC   = 4;
    localparam int WAKE_CYC      = 6;
    localparam int DONE_WAIT_CYC = 5;
    localparam int CLK_HI_CYC    = 2;
    localparam int CLK_LO_CYC    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] total_bytes_i = '0;
    logic [1:0]       mode_i = 2'd0;
    logic [7:0]       s_data_i = 8'h00;
    logic             s_valid_i = 1'b0;
    logic             s_ready_o, cfg_rst_n_o, cfg_clk_o, cfg_ser_o;
    logic [7:0]       cfg_par_o;
    logic             tgt_status_i = 1'b1;
    logic             tgt_done_i = 1'b1;
    logic             busy_o, ok_o, err_o;
    logic [CNT_W-1:0] fail_count_o;

    int         n_checks = 0;
    int         n_fail = 0;
    logic [8:0] exp_q[$];
    logic [1:0] cur_mode = 2'd0;
    int         edges_seen = 0;
    int         ready_hi_viol = 0;
    int         rst_low_cnt = 0;
    int         wake_cnt = 0;
    bit         wake_armed = 1'b0;
    logic       prev_clk = 1'b0, prev_rst = 1'b1, prev_busy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_loader #(
        .CNT_W(CNT_W), .RST_LOW_CYC(RST_LOW_CYC), .WAKE_CYC(WAKE_CYC),
        .DONE_WAIT_CYC(DONE_WAIT_CYC), .CLK_HI_CYC(CLK_HI_CYC), .CLK_LO_CYC(CLK_LO_CYC)
    ) u_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_bytes_i(total_bytes_i),
        .mode_i(mode_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
        .cfg_rst_n_o(cfg_rst_n_o), .cfg_clk_o(cfg_clk_o), .cfg_ser_o(cfg_ser_o),
        .cfg_par_o(cfg_par_o), .tgt_status_i(tgt_status_i), .tgt_done_i(tgt_done_i),
        .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .fail_count_o(fail_count_o)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every configuration clock rise and times the reset phases.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !prev_busy && !cfg_rst_n_o) rst_low_cnt = 1;
            else if (busy_o && !cfg_rst_n_o) rst_low_cnt++;
            if (cfg_rst_n_o && !prev_rst && busy_o) begin
                check(rst_low_cnt == RST_LOW_CYC, "R2", "reset low cycles", rst_low_cnt, RST_LOW_CYC);
                wake_cnt = 0;
                wake_armed = 1'b1;
            end else if (wake_armed && !cfg_clk_o) begin
                wake_cnt++;
            end
            if (cfg_clk_o && s_ready_o) ready_hi_viol++;
            if (cfg_clk_o && !prev_clk) begin
                if (wake_armed) begin
                    check(wake_cnt >= WAKE_CYC, "R3", "wake cycles", wake_cnt, WAKE_CYC);
                    wake_armed = 1'b0;
                end
                edges_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected clock rise", edges_seen, 0);
                end else begin
                    logic [8:0] item;
                    item = exp_q.pop_front();
                    if (!item[8]) begin
                        if (cur_mode == 2'd0)
                            check(cfg_ser_o == item[0] && cfg_par_o == 8'h00, "R7",
                                  "serial bit", {cfg_par_o, cfg_ser_o}, {8'h00, item[0]});
                        else if (cur_mode == 2'd2)
                            check(cfg_par_o == item[7:0] && !cfg_ser_o, "R9",
                                  "secure word", cfg_par_o, item[7:0]);
                        else
                            check(cfg_par_o == item[7:0] && !cfg_ser_o, "R8",
                                  "parallel word", cfg_par_o, item[7:0]);
                    end
                end
            end
            prev_clk  = cfg_clk_o;
            prev_rst  = cfg_rst_n_o;
            prev_busy = busy_o;
        end
    end

    // Driver: offers bytes on the stream and pushes the expected pulses once a byte is taken.
    task automatic send_stream(input logic [7:0] data[$], input logic [1:0] m);
        foreach (data[i]) begin
            bit taken = 1'b0;
            bit gone = 1'b0;
            s_data_i  = data[i];
            s_valid_i = 1'b1;
            while (!taken && !gone) begin
                @(negedge clk);
                if (!busy_o) begin
                    gone = 1'b1;
                end else if (s_ready_o) begin
                    if (m == 2'd0) begin
                        for (int b = 0; b < 8; b++) exp_q.push_back({1'b0, 7'b0, data[i][b]});
                    end else if (m == 2'd2) begin
                        for (int k = 0; k < 4; k++) exp_q.push_back({1'b0, data[i]});
                    end else begin
                        exp_q.push_back({1'b0, data[i]});
                    end
                    @(posedge clk);
                    #1;
                    taken = 1'b1;
                end
            end
            if (gone) break;
        end
        s_valid_i = 1'b0;
    endtask

    task automatic start_load(input int total, input logic [1:0] m);
        @(negedge clk);
        cur_mode      = m;
        start_i       = 1'b1;
        total_bytes_i = CNT_W'(total);
        mode_i        = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic full_load(input logic [7:0] data[$], input logic [1:0] m, input string req);
        int base;
        int want;
        base = edges_seen;
        want = (m == 2'd0) ? 8 : ((m == 2'd2) ? 4 : 1);
        want = want * data.size() + 1;
        start_load(data.size(), m);
        send_stream(data, m);
        exp_q.push_back(9'h100);
        wait_idle();
        check(edges_seen - base == want, req, "clock rises", edges_seen - base, want);
        check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d[$];
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !ok_o && !err_o && !s_ready_o && !cfg_clk_o && cfg_rst_n_o && fail_count_o == 0,
              "R1", "idle outputs", {busy_o, ok_o, err_o, s_ready_o, cfg_clk_o, cfg_rst_n_o}, 6'b000001);

        // R7: serial, LSB first
        d = '{8'hA5, 8'h3C};
        full_load(d, 2'd0, "R7");
        check(ok_o && !err_o, "R10", "serial ok", {ok_o, err_o}, 2'b10);

        // R8: parallel
        d = '{8'h12, 8'hF0, 8'h81};
        full_load(d, 2'd1, "R8");
        check(ok_o && !err_o, "R10", "parallel ok", {ok_o, err_o}, 2'b10);

        // R9: secure parallel, four pulses per byte
        d = '{8'h5A, 8'hC3};
        full_load(d, 2'd2, "R9");

        // R8: code 3 behaves as parallel
        d = '{8'h77};
        full_load(d, 2'd3, "R8");

        // R11: zero total rejected without touching pins
        @(negedge clk);
        start_i = 1'b1;
        total_bytes_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o && !ok_o && !busy_o && cfg_rst_n_o && fail_count_o == 0, "R11", "zero total",
              {err_o, ok_o, busy_o, cfg_rst_n_o}, 4'b1001);
        repeat (3) @(negedge clk);
        check(!busy_o && cfg_rst_n_o && !cfg_clk_o, "R11", "pins untouched",
              {busy_o, cfg_rst_n_o, cfg_clk_o}, 3'b010);

        // R12: next accepted start clears err
        start_load(1, 2'd1);
        check(!err_o && !ok_o && busy_o, "R12", "flags cleared on start", {err_o, ok_o, busy_o}, 3'b001);
        d = '{8'h3E};
        send_stream(d, 2'd1);
        exp_q.push_back(9'h100);
        wait_idle();
        check(ok_o, "R10", "single byte ok", ok_o, 1);

        // R6: status drops after two bytes
        base = edges_seen;
        start_load(4, 2'd1);
        d = '{8'h01, 8'h02, 8'h03, 8'h04};
        fork
            send_stream(d, 2'd1);
            begin
                wait (edges_seen == base + 2);
                tgt_status_i = 1'b0;
            end
        join
        wait_idle();
        check(err_o && !ok_o && fail_count_o == 2, "R6", "status abort count", fail_count_o, 2);
        check(!cfg_rst_n_o && !cfg_clk_o && cfg_par_o == 0 && !cfg_ser_o, "R12", "abort pins",
              {cfg_rst_n_o, cfg_clk_o, cfg_par_o}, 0);
        check(exp_q.size() == 0 && edges_seen - base == 2, "R6", "no clock after status loss",
              edges_seen - base, 2);
        repeat (4) @(negedge clk);
        check(err_o && !cfg_rst_n_o, "R12", "err sticky", {err_o, cfg_rst_n_o}, 2'b10);
        tgt_status_i = 1'b1;

        // R10: done low at the end
        tgt_done_i = 1'b0;
        d = '{8'h9C, 8'h44};
        full_load(d, 2'd1, "R10");
        check(err_o && !ok_o && fail_count_o == 2, "R10", "done low abort", fail_count_o, 2);
        tgt_done_i = 1'b1;

        // R13: start while busy ignored, mode and total latched
        base = edges_seen;
        start_load(2, 2'd0);
        d = '{8'hB2, 8'h6D};
        fork
            send_stream(d, 2'd0);
            begin
                repeat (12) @(negedge clk);
                mode_i = 2'd1;
                total_bytes_i = CNT_W'(7);
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
        join
        exp_q.push_back(9'h100);
        wait_idle();
        check(ok_o && edges_seen - base == 17, "R13", "load kept its mode and total",
              edges_seen - base, 17);
        check(exp_q.size() == 0, "R13", "scoreboard drained", exp_q.size(), 0);

        // R5: ready never seen with the clock high
        check(ready_hi_viol == 0, "R5", "ready during clock high", ready_hi_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule